// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

The router gathers up to 64 device interrupt request lines into one global request register and hands them to four processors. Each processor owns a mask register, and its enabled view of the requests is the mask ANDed with the global request register. Each processor's level-1 interrupt output is raised whenever any bit of that enabled view is set. Devices raise and drop their lines through assert and deassert strobes. Software reads the registers and changes a mask through 64-bit accesses on a simple memory-mapped bus.

Besides the level outputs, the router reports every change as a discrete event: a post or a clear for one line on one processor. A mask write compares the old mask with the new one and emits events only for bits that changed. A device strobe emits events for each processor that has the line enabled. A single change can produce several events. These are delivered one per cycle, and all inputs are held off until the last event has gone out.

Top module: `ilr_router`

## Requirements
- R1: The register slot is the byte offset shifted right by 6, and the low six offset bits are ignored. Slot 0 is the global request register, slots 1 to 4 are the masks of CPU 0 to 3, and slots 5 to 8 are the masked-request registers of CPU 0 to 3. An access is accepted in a cycle where `bus_req` and `bus_rdy` are both high. `bus_ack` is high for exactly the following cycle, and `bus_rdata` carries the value read.
- R2: Only `bus_size` = 3 (eight bytes) is legal. Any other size is acknowledged with `bus_err` high and `bus_rdata` zero, and it changes no register.
- R3: A write to slot 0 or slots 5 to 8, and any access to a slot above 8, is acknowledged with `bus_err` high and changes nothing.
- R4: A masked-request register always reads as that CPU's mask ANDed with the global request register.
- R5: On a mask write, each bit that turns from 0 to 1 while its request bit is set produces one post event for that CPU and line.
- R6: On a mask write, each bit that turns from 1 to 0 while its request bit is set produces one clear event for that CPU and line.
- R7: A device assert sets the line's request bit and posts the line to every CPU whose mask has that bit set.
- R8: A device deassert of a line whose request bit is already clear changes nothing and produces no event.
- R9: A device deassert of a set line clears the request bit and sends a clear to every CPU whose masked-request value had the bit.
- R10: After reset every register reads zero, all interrupt outputs are low and all ready outputs are high.
- R11: `irq_lvl[c]` is the OR of all bits of CPU c's masked-request value.
- R12: Events are single-cycle pulses on `evt_post` or `evt_clr`, carrying `evt_cpu` and `evt_line`. Within one operation they are ordered by ascending CPU, then by ascending line. While any remain, every ready output is low.
- R13: When idle, a bus request takes precedence over a deassert, and a deassert takes precedence over an assert. `dev_clr_rdy` is low while `bus_req` is high, and `dev_set_rdy` is low while `bus_req` or `dev_clr_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | log2 of access bytes, 3 = 64-bit |
| bus_addr | input | 12 | Byte offset from the block base |
| bus_wdata | input | 64 | Write data |
| bus_rdy | output | 1 | Bus access can be accepted |
| bus_ack | output | 1 | Response valid |
| bus_err | output | 1 | Response carries an error |
| bus_rdata | output | 64 | Read data |
| dev_set_vld | input | 1 | Device assert strobe |
| dev_set_line | input | 6 | Line being asserted |
| dev_set_rdy | output | 1 | Assert strobe accepted this cycle |
| dev_clr_vld | input | 1 | Device deassert strobe |
| dev_clr_line | input | 6 | Line being deasserted |
| dev_clr_rdy | output | 1 | Deassert strobe accepted this cycle |
| irq_lvl | output | 4 | Level-1 interrupt per CPU |
| evt_post | output | 1 | Post event pulse |
| evt_clr | output | 1 | Clear event pulse |
| evt_cpu | output | 2 | CPU of the event |
| evt_line | output | 6 | Line of the event |

## Verification
Several rules are checked on every cycle by the assertions: post and clear events never coincide, events within a burst rise in CPU and line order, every ready output stays low while events remain, arbitration precedence holds, every accepted access is answered in the next cycle, a narrow access answers with an error and leaves the masks untouched, and a spurious deassert leaves the request register unchanged. The set of events a mask write or strobe should produce, the read-back values of the mask and masked-request registers, and the resulting interrupt levels depend on the history of requests and masks. Only the bench's scenarios, which compare against a model of that history, can show these.

// File: rtl/ilr_pkg.sv
`timescale 1ns/1ps
package ilr_pkg;

  // Which kind of register a bus slot selects
  typedef enum logic [1:0] {
    SLOT_REQ  = 2'd0,
    SLOT_MASK = 2'd1,
    SLOT_MSKD = 2'd2,
    SLOT_NONE = 2'd3
  } ilr_slot_e;

  // Size code of the only legal access (2**3 bytes)
  localparam logic [1:0] SIZE_DWORD = 2'd3;

  // Byte offset bits consumed inside one register slot
  localparam int SLOT_SHIFT = 6;

endpackage

// File: rtl/ilr_decode.sv
`timescale 1ns/1ps
module ilr_decode
  import ilr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              we,
  output ilr_slot_e         slot_cls,
  output logic [CPU_W-1:0]  slot_cpu,
  output logic              acc_err
);

  logic [SLOT_W-1:0] slot;
  int                slot_i;

  assign slot   = addr[ADDR_W-1:SLOT_SHIFT];
  assign slot_i = int'(slot);

  always_comb begin
    slot_cls = SLOT_NONE;
    slot_cpu = '0;
    if (slot_i == 0) begin
      slot_cls = SLOT_REQ;
    end else if (slot_i <= NUM_CPU) begin
      slot_cls = SLOT_MASK;
      slot_cpu = CPU_W'(slot_i - 1);
    end else if (slot_i <= 2 * NUM_CPU) begin
      slot_cls = SLOT_MSKD;
      slot_cpu = CPU_W'(slot_i - 1 - NUM_CPU);
    end
  end

  always_comb begin
    acc_err = 1'b0;
    if (size != SIZE_DWORD)                 acc_err = 1'b1;
    else if (slot_cls == SLOT_NONE)         acc_err = 1'b1;
    else if (we && (slot_cls != SLOT_MASK)) acc_err = 1'b1;
  end

endmodule

// File: rtl/ilr_irq_state.sv
`timescale 1ns/1ps
module ilr_irq_state #(
  parameter int NUM_CPU  = 4,
  parameter int NUM_LINE = 64,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LINE_W  = $clog2(NUM_LINE)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               mask_we,
  input  logic [CPU_W-1:0]                   mask_cpu,
  input  logic [NUM_LINE-1:0]                mask_wdata,
  input  logic                               set_en,
  input  logic [LINE_W-1:0]                  set_line,
  input  logic                               clr_en,
  input  logic [LINE_W-1:0]                  clr_line,
  output logic [NUM_LINE-1:0]                req_q,
  output logic [NUM_CPU-1:0][NUM_LINE-1:0]   mask_q,
  output logic [NUM_CPU-1:0][NUM_LINE-1:0]   masked,
  output logic [NUM_CPU-1:0][NUM_LINE-1:0]   post_ev,
  output logic [NUM_CPU-1:0][NUM_LINE-1:0]   clr_ev
);

  logic [NUM_LINE-1:0] req_d;
  logic                req_en;
  logic [NUM_LINE-1:0] set_hot;
  logic [NUM_LINE-1:0] clr_hot;
  logic                clr_live;

  assign set_hot  = NUM_LINE'(1) << set_line;
  assign clr_hot  = NUM_LINE'(1) << clr_line;
  assign clr_live = clr_en && req_q[clr_line];

  // Global request register
  assign req_en = set_en | clr_live;

  always_comb begin
    req_d = req_q;
    if (set_en)   req_d = req_d | set_hot;
    if (clr_live) req_d = req_d & ~clr_hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  // Per-CPU mask register, enabled view and event vectors
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic                mask_en;
    logic [NUM_LINE-1:0] changed;

    assign mask_en   = mask_we && (mask_cpu == CPU_W'(c));
    assign masked[c] = mask_q[c] & req_q;
    assign changed   = mask_q[c] ^ mask_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q[c] <= '0;
      else if (mask_en) mask_q[c] <= mask_wdata;
    end

    always_comb begin
      post_ev[c] = '0;
      clr_ev[c]  = '0;
      if (mask_en) begin
        post_ev[c] = changed & mask_wdata & req_q;
        clr_ev[c]  = changed & masked[c];
      end else if (set_en) begin
        post_ev[c] = mask_q[c] & set_hot;
      end else if (clr_live) begin
        clr_ev[c]  = masked[c] & clr_hot;
      end
    end
  end

endmodule

// File: rtl/ilr_evt_sched.sv
`timescale 1ns/1ps
module ilr_evt_sched #(
  parameter int NUM_CPU  = 4,
  parameter int NUM_LINE = 64,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LINE_W  = $clog2(NUM_LINE)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load,
  input  logic [NUM_CPU-1:0][NUM_LINE-1:0] post_in,
  input  logic [NUM_CPU-1:0][NUM_LINE-1:0] clr_in,
  output logic                             busy,
  output logic                             evt_post,
  output logic                             evt_clr,
  output logic [CPU_W-1:0]                 evt_cpu,
  output logic [LINE_W-1:0]                evt_line
);

  logic [NUM_CPU-1:0][NUM_LINE-1:0] post_q, post_d;
  logic [NUM_CPU-1:0][NUM_LINE-1:0] clr_q, clr_d;
  logic [NUM_CPU-1:0]               cpu_hit;
  logic [CPU_W-1:0]                 sel_cpu;
  logic [LINE_W-1:0]                sel_line;
  logic [NUM_LINE-1:0]              sel_vec;
  logic                             pend_en;

  function automatic logic [LINE_W-1:0] lowest_set(input logic [NUM_LINE-1:0] v);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = NUM_LINE - 1; i >= 0; i--) begin
      if (v[i]) r = LINE_W'(i);
    end
    return r;
  endfunction

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_hit
    assign cpu_hit[c] = |(post_q[c] | clr_q[c]);
  end

  assign busy = |cpu_hit;

  always_comb begin
    sel_cpu = '0;
    for (int c = NUM_CPU - 1; c >= 0; c--) begin
      if (cpu_hit[c]) sel_cpu = CPU_W'(c);
    end
  end

  assign sel_vec  = post_q[sel_cpu] | clr_q[sel_cpu];
  assign sel_line = lowest_set(sel_vec);

  assign evt_post = busy &&  post_q[sel_cpu][sel_line];
  assign evt_clr  = busy && !post_q[sel_cpu][sel_line];
  assign evt_cpu  = sel_cpu;
  assign evt_line = sel_line;

  // Next state: load a fresh batch when idle, else retire one event
  assign pend_en = load | busy;

  always_comb begin
    post_d = post_q;
    clr_d  = clr_q;
    if (load) begin
      post_d = post_in;
      clr_d  = clr_in;
    end else if (busy) begin
      post_d[sel_cpu][sel_line] = 1'b0;
      clr_d[sel_cpu][sel_line]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q <= '0;
      clr_q  <= '0;
    end else if (pend_en) begin
      post_q <= post_d;
      clr_q  <= clr_d;
    end
  end

endmodule

// File: rtl/ilr_router.sv
`timescale 1ns/1ps
module ilr_router
  import ilr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 64,
  parameter int NUM_CPU  = 4,
  parameter int NUM_LINE = 64,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LINE_W  = $clog2(NUM_LINE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [1:0]         bus_size,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_rdy,
  output logic               bus_ack,
  output logic               bus_err,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               dev_set_vld,
  input  logic [LINE_W-1:0]  dev_set_line,
  output logic               dev_set_rdy,
  input  logic               dev_clr_vld,
  input  logic [LINE_W-1:0]  dev_clr_line,
  output logic               dev_clr_rdy,
  output logic [NUM_CPU-1:0] irq_lvl,
  output logic               evt_post,
  output logic               evt_clr,
  output logic [CPU_W-1:0]   evt_cpu,
  output logic [LINE_W-1:0]  evt_line
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_i_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_i_n  <= rst_s1_q;
    end
  end

  ilr_slot_e                        slot_cls;
  logic [CPU_W-1:0]                 slot_cpu;
  logic                             acc_err;
  logic                             busy;
  logic                             bus_go, set_go, clr_go;
  logic                             mask_we;
  logic                             ev_load;
  logic [NUM_LINE-1:0]              req_w;
  logic [NUM_CPU-1:0][NUM_LINE-1:0] mask_w;
  logic [NUM_CPU-1:0][NUM_LINE-1:0] masked_w;
  logic [NUM_CPU-1:0][NUM_LINE-1:0] post_ev;
  logic [NUM_CPU-1:0][NUM_LINE-1:0] clr_ev;
  logic [DATA_W-1:0]                rd_mux;
  logic                             ack_d, err_d;
  logic [DATA_W-1:0]                rdata_d;

  ilr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_CPU (NUM_CPU)
  ) u_decode (
    .addr     (bus_addr),
    .size     (bus_size),
    .we       (bus_we),
    .slot_cls (slot_cls),
    .slot_cpu (slot_cpu),
    .acc_err  (acc_err)
  );

  // Arbitration: bus, then deassert, then assert; nothing while busy
  assign bus_rdy     = !busy;
  assign dev_clr_rdy = !busy && !bus_req;
  assign dev_set_rdy = !busy && !bus_req && !dev_clr_vld;

  assign bus_go  = bus_req && bus_rdy;
  assign clr_go  = dev_clr_vld && dev_clr_rdy;
  assign set_go  = dev_set_vld && dev_set_rdy;
  assign mask_we = bus_go && bus_we && !acc_err;
  assign ev_load = mask_we || set_go || clr_go;

  ilr_irq_state #(
    .NUM_CPU  (NUM_CPU),
    .NUM_LINE (NUM_LINE)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .mask_we    (mask_we),
    .mask_cpu   (slot_cpu),
    .mask_wdata (bus_wdata[NUM_LINE-1:0]),
    .set_en     (set_go),
    .set_line   (dev_set_line),
    .clr_en     (clr_go),
    .clr_line   (dev_clr_line),
    .req_q      (req_w),
    .mask_q     (mask_w),
    .masked     (masked_w),
    .post_ev    (post_ev),
    .clr_ev     (clr_ev)
  );

  ilr_evt_sched #(
    .NUM_CPU  (NUM_CPU),
    .NUM_LINE (NUM_LINE)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (ev_load),
    .post_in  (post_ev),
    .clr_in   (clr_ev),
    .busy     (busy),
    .evt_post (evt_post),
    .evt_clr  (evt_clr),
    .evt_cpu  (evt_cpu),
    .evt_line (evt_line)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
    assign irq_lvl[c] = |masked_w[c];
  end

  // Read data selection
  always_comb begin
    unique case (slot_cls)
      SLOT_REQ:  rd_mux = DATA_W'(req_w);
      SLOT_MASK: rd_mux = DATA_W'(mask_w[slot_cpu]);
      SLOT_MSKD: rd_mux = DATA_W'(masked_w[slot_cpu]);
      default:   rd_mux = '0;
    endcase
  end

  // Response next state and register
  always_comb begin
    ack_d   = bus_go;
    err_d   = bus_go && acc_err;
    rdata_d = '0;
    if (bus_go && !bus_we && !acc_err) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= ack_d;
      bus_err   <= err_d;
      bus_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/ilr_checks.sv
`timescale 1ns/1ps
module ilr_checks #(
  parameter int NUM_CPU  = 4,
  parameter int NUM_LINE = 64,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int LINE_W  = $clog2(NUM_LINE)
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             bus_req,
  input logic                             bus_rdy,
  input logic [1:0]                       bus_size,
  input logic                             bus_ack,
  input logic                             bus_err,
  input logic                             dev_set_rdy,
  input logic                             dev_clr_vld,
  input logic                             dev_clr_rdy,
  input logic [LINE_W-1:0]                dev_clr_line,
  input logic                             evt_post,
  input logic                             evt_clr,
  input logic [CPU_W-1:0]                 evt_cpu,
  input logic [LINE_W-1:0]                evt_line,
  input logic [NUM_LINE-1:0]              req_w,
  input logic [NUM_CPU-1:0][NUM_LINE-1:0] mask_w
);

  logic evt_any;
  assign evt_any = evt_post || evt_clr;

  a_r1_ack_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rdy) |=> bus_ack);

  a_r1_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_rdy) |=> !bus_ack);

  a_r2_narrow_errs: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rdy && bus_size != 2'd3) |=> (bus_ack && bus_err));

  a_r2_narrow_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_rdy && bus_size != 2'd3) |=> $stable(mask_w));

  a_r8_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_clr_vld && dev_clr_rdy && !req_w[dev_clr_line]) |=>
      ($stable(req_w) && !evt_post && !evt_clr));

  a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_post && evt_clr));

  a_r12_hold_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |-> (!bus_rdy && !dev_clr_rdy && !dev_set_rdy));

  a_r12_cpu_order: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && $past(evt_any)) |-> (evt_cpu >= $past(evt_cpu)));

  a_r12_line_order: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_any && $past(evt_any) && evt_cpu == $past(evt_cpu)) |->
      (evt_line > $past(evt_line)));

  a_r13_bus_first: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (!dev_clr_rdy && !dev_set_rdy));

  a_r13_clr_before_set: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clr_vld |-> !dev_set_rdy);

endmodule

bind ilr_router ilr_checks #(
  .NUM_CPU  (NUM_CPU),
  .NUM_LINE (NUM_LINE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_i_n),
  .bus_req      (bus_req),
  .bus_rdy      (bus_rdy),
  .bus_size     (bus_size),
  .bus_ack      (bus_ack),
  .bus_err      (bus_err),
  .dev_set_rdy  (dev_set_rdy),
  .dev_clr_vld  (dev_clr_vld),
  .dev_clr_rdy  (dev_clr_rdy),
  .dev_clr_line (dev_clr_line),
  .evt_post     (evt_post),
  .evt_clr      (evt_clr),
  .evt_cpu      (evt_cpu),
  .evt_line     (evt_line),
  .req_w        (req_w),
  .mask_w       (mask_w)
);

// File: tb/sim_ilr_router.sv
`timescale 1ns/1ps
module sim_ilr_router;

  localparam int ADDR_W = 12;
  localparam int NCPU   = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [ADDR_W-1:0] bus_addr;
  logic [63:0] bus_wdata;
  logic        bus_rdy, bus_ack, bus_err;
  logic [63:0] bus_rdata;
  logic        dev_set_vld, dev_set_rdy, dev_clr_vld, dev_clr_rdy;
  logic [5:0]  dev_set_line, dev_clr_line;
  logic [3:0]  irq_lvl;
  logic        evt_post, evt_clr;
  logic [1:0]  evt_cpu;
  logic [5:0]  evt_line;

  always #2.5 clk = ~clk;

  ilr_router u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdy(bus_rdy), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .dev_set_vld(dev_set_vld), .dev_set_line(dev_set_line), .dev_set_rdy(dev_set_rdy),
    .dev_clr_vld(dev_clr_vld), .dev_clr_line(dev_clr_line), .dev_clr_rdy(dev_clr_rdy),
    .irq_lvl(irq_lvl), .evt_post(evt_post), .evt_clr(evt_clr),
    .evt_cpu(evt_cpu), .evt_line(evt_line)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Observed events (kind 1 = post, 0 = clear)
  bit         ev_kind [512];
  logic [1:0] ev_cpu  [512];
  logic [5:0] ev_ln   [512];
  int         ev_n = 0;

  // Expected events for the current operation
  bit         x_kind [256];
  logic [1:0] x_cpu  [256];
  logic [5:0] x_ln   [256];
  int         x_n;

  // Model of the requirements
  logic [63:0] m_mask [NCPU];
  logic [63:0] m_req;

  always @(negedge clk) begin
    if (rst_n && (evt_post || evt_clr) && ev_n < 512) begin
      ev_kind[ev_n] = evt_post;
      ev_cpu[ev_n]  = evt_cpu;
      ev_ln[ev_n]   = evt_line;
      ev_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input bit k, input int c, input int l);
    x_kind[x_n] = k; x_cpu[x_n] = 2'(c); x_ln[x_n] = 6'(l); x_n++;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!bus_rdy) @(negedge clk);
  endtask

  task automatic cmp_events(input int base, input string tag);
    int got;
    got = ev_n - base;
    chk(got == x_n, {tag, " event count"}, 64'(got), 64'(x_n));
    for (int i = 0; i < x_n && i < got; i++) begin
      chk(ev_kind[base+i] == x_kind[i] && ev_cpu[base+i] == x_cpu[i] && ev_ln[base+i] == x_ln[i],
          {tag, " event"},
          {55'd0, ev_kind[base+i], ev_cpu[base+i], ev_ln[base+i]},
          {55'd0, x_kind[i], x_cpu[i], x_ln[i]});
    end
  endtask

  task automatic bus_op(input bit we, input logic [1:0] sz, input int slot, input logic [63:0] wd,
                        output logic [63:0] rd, output bit er, output bit rdy_after);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz;
    bus_addr = ADDR_W'(slot * 64); bus_wdata = wd;
    while (!bus_rdy) @(negedge clk);
    @(negedge clk);
    bus_req = 1'b0;
    rd = bus_rdata; er = bus_err; rdy_after = bus_rdy;
    chk(bus_ack == 1'b1, "R1 ack one cycle after accept", 64'(bus_ack), 64'd1);
  endtask

  task automatic rd_chk(input int slot, input logic [63:0] exp, input string tag);
    logic [63:0] rd; bit er, ra;
    bus_op(1'b0, 2'd3, slot, 64'd0, rd, er, ra);
    chk(rd == exp && !er, tag, rd, exp);
  endtask

  task automatic chk_irq(input string tag);
    logic [3:0] e;
    for (int c = 0; c < NCPU; c++) e[c] = |(m_mask[c] & m_req);
    chk(irq_lvl == e, tag, 64'(irq_lvl), 64'(e));
  endtask

  task automatic do_mask(input int c, input logic [63:0] w, input string tag);
    logic [63:0] rd; bit er, ra; int base;
    x_n = 0; base = ev_n;
    for (int b = 0; b < 64; b++) begin
      if ((m_mask[c][b] != w[b]) && m_req[b]) push(w[b], c, b);
    end
    m_mask[c] = w;
    bus_op(1'b1, 2'd3, 1 + c, w, rd, er, ra);
    chk(!er, {tag, " mask write error"}, 64'(er), 64'd0);
    if (x_n > 0) chk(!ra, "R12 bus held while events pending", 64'(ra), 64'd0);
    wait_idle();
    cmp_events(base, tag);
  endtask

  task automatic do_set(input int n, input string tag);
    int base;
    x_n = 0; base = ev_n;
    m_req[n] = 1'b1;
    for (int c = 0; c < NCPU; c++) if (m_mask[c][n]) push(1'b1, c, n);
    @(negedge clk);
    dev_set_vld = 1'b1; dev_set_line = 6'(n);
    while (!dev_set_rdy) @(negedge clk);
    @(negedge clk);
    dev_set_vld = 1'b0;
    while (!bus_rdy) @(negedge clk);
    cmp_events(base, tag);
  endtask

  task automatic do_clr(input int n, input string tag);
    int base;
    x_n = 0; base = ev_n;
    if (m_req[n]) begin
      for (int c = 0; c < NCPU; c++) if (m_mask[c][n]) push(1'b0, c, n);
      m_req[n] = 1'b0;
    end
    @(negedge clk);
    dev_clr_vld = 1'b1; dev_clr_line = 6'(n);
    while (!dev_clr_rdy) @(negedge clk);
    @(negedge clk);
    dev_clr_vld = 1'b0;
    while (!bus_rdy) @(negedge clk);
    cmp_events(base, tag);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(bus_rdy && dev_set_rdy && dev_clr_rdy, "R10 ready after reset", 64'({bus_rdy, dev_set_rdy, dev_clr_rdy}), 64'd7);
    chk(irq_lvl == 4'd0, "R10 irq low after reset", 64'(irq_lvl), 64'd0);
    for (int s = 0; s <= 2 * NCPU; s++) rd_chk(s, 64'd0, "R10 register zero after reset");
  endtask

  task automatic t_mask_quiet();
    do_mask(0, 64'h0000_0000_0000_0020, "R5 mask write without requests");
    do_mask(2, 64'h8000_0000_0000_0020, "R5 mask write without requests");
    rd_chk(1, 64'h0000_0000_0000_0020, "R1 mask cpu0 readback");
    rd_chk(3, 64'h8000_0000_0000_0020, "R1 mask cpu2 readback");
    chk_irq("R11 irq idle with no requests");
  endtask

  task automatic t_dev_assert();
    do_set(5, "R7 assert posts to masked cpus");
    chk_irq("R11 irq after assert");
    rd_chk(0, m_req, "R7 request register after assert");
    rd_chk(5 + 2, m_mask[2] & m_req, "R4 masked cpu2 after assert");
  endtask

  task automatic t_mask_multi();
    do_set(3, "R7 assert with no mask");
    do_set(40, "R7 assert with no mask");
    do_set(63, "R7 assert to cpu2 line 63");
    do_mask(1, 64'h8000_0100_0000_0088, "R5 R12 mask write posts ascending");
    chk_irq("R11 irq after mask post");
    do_mask(1, 64'h0000_0100_0000_0002, "R6 mask write clears");
    rd_chk(5 + 1, m_mask[1] & m_req, "R4 masked cpu1 after clears");
    chk_irq("R11 irq after mask clear");
  endtask

  task automatic t_narrow();
    logic [63:0] rd; bit er, ra; int base;
    base = ev_n; x_n = 0;
    bus_op(1'b1, 2'd2, 1, 64'hFFFF_FFFF_FFFF_FFFF, rd, er, ra);
    chk(er, "R2 narrow write errors", 64'(er), 64'd1);
    bus_op(1'b0, 2'd0, 1, 64'd0, rd, er, ra);
    chk(er && rd == 64'd0, "R2 narrow read errors with zero data", rd, 64'd0);
    wait_idle();
    cmp_events(base, "R2 narrow access");
    rd_chk(1, m_mask[0], "R2 mask cpu0 unchanged by narrow write");
  endtask

  task automatic t_readonly();
    logic [63:0] rd; bit er, ra;
    bus_op(1'b1, 2'd3, 0, 64'd0, rd, er, ra);
    chk(er, "R3 write to request register errors", 64'(er), 64'd1);
    rd_chk(0, m_req, "R3 request register unchanged");
    bus_op(1'b1, 2'd3, 5 + 1, 64'hFFFF, rd, er, ra);
    chk(er, "R3 write to masked register errors", 64'(er), 64'd1);
    rd_chk(5 + 1, m_mask[1] & m_req, "R3 masked register unchanged");
    bus_op(1'b0, 2'd3, 12, 64'd0, rd, er, ra);
    chk(er && rd == 64'd0, "R3 unmapped slot errors", rd, 64'd0);
  endtask

  task automatic t_spurious();
    do_clr(10, "R8 deassert of clear line");
    rd_chk(0, m_req, "R8 request register unchanged");
    chk_irq("R8 irq unchanged");
  endtask

  task automatic t_deassert();
    do_clr(5, "R9 deassert clears masked cpus");
    rd_chk(0, m_req, "R9 request bit cleared");
    chk_irq("R9 R11 irq after deassert");
    do_clr(40, "R9 deassert clears cpu1");
    chk_irq("R9 R11 irq after second deassert");
  endtask

  task automatic t_arbitrate();
    int base;
    base = ev_n;
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_size = 2'd3; bus_addr = '0;
    dev_clr_vld = 1'b1; dev_clr_line = 6'd20;
    dev_set_vld = 1'b1; dev_set_line = 6'd21;
    #1;
    chk(bus_rdy && !dev_clr_rdy && !dev_set_rdy, "R13 bus wins",
        64'({bus_rdy, dev_clr_rdy, dev_set_rdy}), 64'b100);
    @(negedge clk);
    bus_req = 1'b0;
    chk(bus_ack, "R13 bus served first", 64'(bus_ack), 64'd1);
    #1;
    chk(dev_clr_rdy && !dev_set_rdy, "R13 deassert before assert",
        64'({dev_clr_rdy, dev_set_rdy}), 64'b10);
    @(negedge clk);
    dev_clr_vld = 1'b0;
    #1;
    chk(dev_set_rdy, "R13 assert served last", 64'(dev_set_rdy), 64'd1);
    @(negedge clk);
    dev_set_vld = 1'b0;
    m_req[21] = 1'b1;
    wait_idle();
    x_n = 0;
    cmp_events(base, "R13 arbitration");
    rd_chk(0, m_req, "R13 both strobes applied");
  endtask

  initial begin
    rst_n = 1'b0;
    bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'd3; bus_addr = '0; bus_wdata = '0;
    dev_set_vld = 1'b0; dev_set_line = '0; dev_clr_vld = 1'b0; dev_clr_line = '0;
    m_req = '0;
    for (int c = 0; c < NCPU; c++) m_mask[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mask_quiet();
    t_dev_assert();
    t_mask_multi();
    t_narrow();
    t_readonly();
    t_spurious();
    t_deassert();
    t_arbitrate();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule